// File: doc/BRIEF.md
# Saved-Status Register Access Router

This block sits beside the system-register access path of a processor core. When an instruction reads or writes the saved-status register, the block receives the raw encoding fields, the access direction, the current exception level, the three nested-virtualisation control bits, the host-mode flag and the inputs that govern the exception-return lock. From these it picks a single outcome:

- complete on the level-1 copy of the register;
- complete on the level-2 copy;
- redirect to a memory slot;
- trap to level 2;
- raise an undefined-instruction fault;
- raise a lock fault.

The block decodes three encodings, or aliases, of the register, all with op0=11, CRn=0100, CRm=0000 and op2=000:

| Alias | op1 |
|---|---|
| Own-level | 000 |
| Lower-from-hypervisor | 101 |
| Hypervisor | 100 |

Any other encoding is reported as a no-match, and the router takes no action on it.

The decision is registered. It appears one clock after a request is accepted and stays for one cycle, together with a trap syndrome class and a memory slot offset. The neighbouring logic performs the actual memory access and the trap vectoring.

Top module: `ssr_access_router`

## Requirements
- R1: A request whose encoding is not one of the three aliases gives `nomatch_o`=1, `dec_valid_o`=0 and `outcome_o`=0 in the following cycle. A matched request gives `dec_valid_o`=1 and `nomatch_o`=0.
- R2: Any access to any alias at exception level 0 (`el_i`=0) gives the undefined outcome. This holds for reads and writes.
- R3: Own-level alias at level 1, with the nested bits taken as {nv2,nv1,nv0}:
  - pattern 011 traps to level 2;
  - pattern 111 redirects to memory;
  - every other pattern accesses the level-1 copy.
- R4: Own-level alias at level 2 accesses the level-2 copy when `host_mode_i`=1 and the level-1 copy otherwise. At level 3 it always accesses the level-1 copy.
- R5: Lower-from-hypervisor alias at level 1:
  - pattern 101 redirects to memory;
  - otherwise, nv0=1 traps;
  - otherwise the access is undefined.
  At levels 2 and 3 it accesses the level-1 copy in host mode and is undefined otherwise.
- R6: Hypervisor alias at level 1:
  - nv2=1 and nv0=1 accesses the level-1 copy;
  - otherwise, nv0=1 traps;
  - otherwise the access is undefined.
  At levels 2 and 3 it accesses the level-2 copy.
- R7: A write at level 1 or 2 gives the lock fault, ahead of every outcome except the level-0 fault, when `lock_feat_i`, `lock_en_i` and `lock_bit_i` are 1 and `halted_i` is 0. There is one exception: for the own-level alias at level 1 with nv1=nv0=1, no lock fault is raised and the normal routing applies. Writes at level 3 never give the lock fault.
- R8: A read never gives the lock fault.
- R9: `outcome_o` is one-hot for every matched request, using these bit positions:

  | Bit | Outcome |
  |---|---|
  | 0 | level-1 access |
  | 1 | level-2 access |
  | 2 | memory redirect |
  | 3 | trap |
  | 4 | undefined |
  | 5 | lock fault |

  It is zero when `dec_valid_o`=0. `syndrome_o` is 0x18 exactly with a trap and 0 otherwise. `mem_offset_o` is 0x160 exactly with a memory redirect and 0 otherwise.
- R10: While reset is asserted and after its release, all outputs are 0 until a request is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Access request present this cycle |
| req_write_i | input | 1 | 1 = write, 0 = read |
| el_i | input | 2 | Current exception level |
| op0_i | input | 2 | Encoding field op0 |
| op1_i | input | 3 | Encoding field op1 (selects alias) |
| crn_i | input | 4 | Encoding field CRn |
| crm_i | input | 4 | Encoding field CRm |
| op2_i | input | 3 | Encoding field op2 |
| nv_i | input | 3 | Nested-virtualisation bits {nv2,nv1,nv0} |
| host_mode_i | input | 1 | Host mode active at level 2 |
| lock_feat_i | input | 1 | Lock feature implemented |
| lock_en_i | input | 1 | Lock enabled at current level |
| halted_i | input | 1 | Core in halted debug state |
| lock_bit_i | input | 1 | Live lock state bit |
| dec_valid_o | output | 1 | Decision valid for a matched request |
| nomatch_o | output | 1 | Request matched no alias |
| outcome_o | output | 6 | One-hot outcome |
| syndrome_o | output | 6 | Trap syndrome class |
| mem_offset_o | output | 12 | Memory slot offset for a redirect |

## Verification
The hardest case to reach from the ports is the lock-fault exclusion. A write must arrive at level 1 on the own-level alias, with all four lock conditions met, and with the nested pattern 011 or 111. Only then does the normal trap or redirect win over the lock fault. Random stimulus reaches it rarely, so the lock inputs are biased towards their faulting values and directed writes sweep all eight nested patterns under full lock conditions. Reads under the same conditions are also checked against the lock rule.

// File: rtl/ssr_pkg.sv
package ssr_pkg;

  typedef enum logic [1:0] {
    ALIAS_NONE     = 2'd0,
    ALIAS_OWN      = 2'd1,
    ALIAS_LOWER_HV = 2'd2,
    ALIAS_HV       = 2'd3
  } alias_e;

  // bit positions of the one-hot outcome vector
  typedef enum logic [2:0] {
    OC_ACC_L1 = 3'd0,
    OC_ACC_L2 = 3'd1,
    OC_MEM    = 3'd2,
    OC_TRAP   = 3'd3,
    OC_UNDEF  = 3'd4,
    OC_LOCK   = 3'd5
  } outcome_e;

  localparam int N_OUTCOMES = 6;
  localparam int N_ALIASES  = 3;

  typedef struct packed {
    logic [1:0] op0;
    logic [2:0] op1;
    logic [3:0] crn;
    logic [3:0] crm;
    logic [2:0] op2;
  } sysreg_enc_t;

  localparam logic [1:0] ENC_OP0 = 2'b11;
  localparam logic [3:0] ENC_CRN = 4'b0100;
  localparam logic [3:0] ENC_CRM = 4'b0000;
  localparam logic [2:0] ENC_OP2 = 3'b000;

  localparam logic [2:0] OP1_OWN      = 3'b000;
  localparam logic [2:0] OP1_LOWER_HV = 3'b101;
  localparam logic [2:0] OP1_HV       = 3'b100;

  localparam logic [2:0] NV_OWN_TRAP  = 3'b011;
  localparam logic [2:0] NV_OWN_MEM   = 3'b111;
  localparam logic [2:0] NV_LOWER_MEM = 3'b101;

  localparam logic [1:0] EL0 = 2'd0;
  localparam logic [1:0] EL1 = 2'd1;
  localparam logic [1:0] EL2 = 2'd2;
  localparam logic [1:0] EL3 = 2'd3;

endpackage

// File: rtl/ssr_alias_decode.sv
module ssr_alias_decode
  import ssr_pkg::*;
(
  input  sysreg_enc_t enc_i,
  output alias_e      alias_o
);

  localparam logic [2:0] OP1_TAB [N_ALIASES] = '{OP1_OWN, OP1_LOWER_HV, OP1_HV};
  localparam alias_e     ID_TAB  [N_ALIASES] = '{ALIAS_OWN, ALIAS_LOWER_HV, ALIAS_HV};

  logic                 common_ok;
  logic [N_ALIASES-1:0] hit;

  assign common_ok = (enc_i.op0 == ENC_OP0) && (enc_i.crn == ENC_CRN) &&
                     (enc_i.crm == ENC_CRM) && (enc_i.op2 == ENC_OP2);

  for (genvar g = 0; g < N_ALIASES; g++) begin : g_hit
    assign hit[g] = common_ok && (enc_i.op1 == OP1_TAB[g]);
  end

  always_comb begin
    alias_o = ALIAS_NONE;
    for (int k = 0; k < N_ALIASES; k++) begin
      if (hit[k]) alias_o = ID_TAB[k];
    end
  end

endmodule

// File: rtl/ssr_lock_check.sv
module ssr_lock_check
  import ssr_pkg::*;
(
  input  logic       write_i,
  input  logic [1:0] el_i,
  input  alias_e     alias_i,
  input  logic [2:0] nv_i,
  input  logic       lock_feat_i,
  input  logic       lock_en_i,
  input  logic       halted_i,
  input  logic       lock_bit_i,
  output logic       lock_hit_o
);

  logic level_ok;
  logic armed;
  logic exempt;

  assign level_ok = (el_i == EL1) || (el_i == EL2);
  assign armed    = lock_feat_i && lock_en_i && !halted_i && lock_bit_i;
  // own-level alias at level 1 with nv1 and nv0 both set is excluded
  assign exempt   = (alias_i == ALIAS_OWN) && (el_i == EL1) && (nv_i[1:0] == 2'b11);

  assign lock_hit_o = write_i && level_ok && armed && !exempt &&
                      (alias_i != ALIAS_NONE);

endmodule

// File: rtl/ssr_route_logic.sv
module ssr_route_logic
  import ssr_pkg::*;
(
  input  logic [1:0] el_i,
  input  alias_e     alias_i,
  input  logic [2:0] nv_i,
  input  logic       host_mode_i,
  input  logic       lock_hit_i,
  output outcome_e   oc_o
);

  outcome_e own_oc, lower_oc, hv_oc;

  always_comb begin
    unique case (el_i)
      EL1: begin
        if (nv_i == NV_OWN_TRAP)     own_oc = OC_TRAP;
        else if (nv_i == NV_OWN_MEM) own_oc = OC_MEM;
        else                         own_oc = OC_ACC_L1;
      end
      EL2:     own_oc = host_mode_i ? OC_ACC_L2 : OC_ACC_L1;
      default: own_oc = OC_ACC_L1;
    endcase
  end

  always_comb begin
    if (el_i == EL1) begin
      if (nv_i == NV_LOWER_MEM) lower_oc = OC_MEM;
      else if (nv_i[0])         lower_oc = OC_TRAP;
      else                      lower_oc = OC_UNDEF;
    end else begin
      lower_oc = host_mode_i ? OC_ACC_L1 : OC_UNDEF;
    end
  end

  always_comb begin
    if (el_i == EL1) begin
      if (nv_i[2] && nv_i[0]) hv_oc = OC_ACC_L1;
      else if (nv_i[0])       hv_oc = OC_TRAP;
      else                    hv_oc = OC_UNDEF;
    end else begin
      hv_oc = OC_ACC_L2;
    end
  end

  always_comb begin
    if (el_i == EL0)     oc_o = OC_UNDEF;
    else if (lock_hit_i) oc_o = OC_LOCK;
    else begin
      unique case (alias_i)
        ALIAS_OWN:      oc_o = own_oc;
        ALIAS_LOWER_HV: oc_o = lower_oc;
        ALIAS_HV:       oc_o = hv_oc;
        default:        oc_o = OC_UNDEF;
      endcase
    end
  end

endmodule

// File: rtl/ssr_onehot.sv
module ssr_onehot #(
  parameter int N     = 6,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [IDX_W-1:0] idx_i,
  output logic [N-1:0]     oh_o
);

  for (genvar g = 0; g < N; g++) begin : g_bit
    assign oh_o[g] = (idx_i == IDX_W'(g));
  end

endmodule

// File: rtl/ssr_access_router.sv
module ssr_access_router
  import ssr_pkg::*;
#(
  parameter int               SYND_W    = 6,
  parameter logic [SYND_W-1:0] TRAP_SYND = 6'h18,
  parameter int               OFF_W     = 12,
  parameter logic [OFF_W-1:0]  MEM_OFF   = 12'h160
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  req_valid_i,
  input  logic                  req_write_i,
  input  logic [1:0]            el_i,
  input  logic [1:0]            op0_i,
  input  logic [2:0]            op1_i,
  input  logic [3:0]            crn_i,
  input  logic [3:0]            crm_i,
  input  logic [2:0]            op2_i,
  input  logic [2:0]            nv_i,
  input  logic                  host_mode_i,
  input  logic                  lock_feat_i,
  input  logic                  lock_en_i,
  input  logic                  halted_i,
  input  logic                  lock_bit_i,
  output logic                  dec_valid_o,
  output logic                  nomatch_o,
  output logic [N_OUTCOMES-1:0] outcome_o,
  output logic [SYND_W-1:0]     syndrome_o,
  output logic [OFF_W-1:0]      mem_offset_o
);

  sysreg_enc_t           enc;
  alias_e                alias_id;
  logic                  lock_hit;
  outcome_e              oc;
  logic [N_OUTCOMES-1:0] oc_oh;
  logic                  matched;

  assign enc = '{op0: op0_i, op1: op1_i, crn: crn_i, crm: crm_i, op2: op2_i};

  ssr_alias_decode u_decode (
    .enc_i   (enc),
    .alias_o (alias_id)
  );

  ssr_lock_check u_lock (
    .write_i     (req_write_i),
    .el_i        (el_i),
    .alias_i     (alias_id),
    .nv_i        (nv_i),
    .lock_feat_i (lock_feat_i),
    .lock_en_i   (lock_en_i),
    .halted_i    (halted_i),
    .lock_bit_i  (lock_bit_i),
    .lock_hit_o  (lock_hit)
  );

  ssr_route_logic u_route (
    .el_i        (el_i),
    .alias_i     (alias_id),
    .nv_i        (nv_i),
    .host_mode_i (host_mode_i),
    .lock_hit_i  (lock_hit),
    .oc_o        (oc)
  );

  ssr_onehot #(.N(N_OUTCOMES)) u_oh (
    .idx_i (oc),
    .oh_o  (oc_oh)
  );

  assign matched = req_valid_i && (alias_id != ALIAS_NONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dec_valid_o  <= 1'b0;
      nomatch_o    <= 1'b0;
      outcome_o    <= '0;
      syndrome_o   <= '0;
      mem_offset_o <= '0;
    end else begin
      dec_valid_o  <= matched;
      nomatch_o    <= req_valid_i && (alias_id == ALIAS_NONE);
      outcome_o    <= matched ? oc_oh : '0;
      syndrome_o   <= (matched && oc == OC_TRAP) ? TRAP_SYND : '0;
      mem_offset_o <= (matched && oc == OC_MEM) ? MEM_OFF : '0;
    end
  end

endmodule

// File: rtl/ssr_router_chk.sv
module ssr_router_chk
  import ssr_pkg::*;
(
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  req_valid_i,
  input logic                  req_write_i,
  input logic [1:0]            el_i,
  input logic                  dec_valid_o,
  input logic                  nomatch_o,
  input logic [N_OUTCOMES-1:0] outcome_o,
  input logic [5:0]            syndrome_o,
  input logic [11:0]           mem_offset_o
);

  p_onehot_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_valid_o |-> ($countones(outcome_o) == 1));

  p_idle_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dec_valid_o |-> (outcome_o == '0));

  p_synd_trap_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (syndrome_o != '0) == outcome_o[OC_TRAP]);

  p_off_mem_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_offset_o != '0) == outcome_o[OC_MEM]);

  p_nomatch_excl_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(nomatch_o && dec_valid_o));

  p_latency_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> (dec_valid_o || nomatch_o));

  p_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !(dec_valid_o || nomatch_o));

  p_el0_undef_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && el_i == EL0) |=> (nomatch_o || outcome_o[OC_UNDEF]));

  p_read_nolock_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_write_i) |=> !outcome_o[OC_LOCK]);

  p_el3_nolock_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && el_i == EL3) |=> !outcome_o[OC_LOCK]);

endmodule

bind ssr_access_router ssr_router_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_valid_i  (req_valid_i),
  .req_write_i  (req_write_i),
  .el_i         (el_i),
  .dec_valid_o  (dec_valid_o),
  .nomatch_o    (nomatch_o),
  .outcome_o    (outcome_o),
  .syndrome_o   (syndrome_o),
  .mem_offset_o (mem_offset_o)
);

// File: tb/ssr_access_router_bench.sv
module ssr_access_router_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0, wr = 1'b0;
  logic [1:0]  el = '0, op0 = '0;
  logic [2:0]  op1 = '0, op2 = '0, nv = '0;
  logic [3:0]  crn = '0, crm = '0;
  logic        host = 1'b0, feat = 1'b0, en = 1'b0, hlt = 1'b0, lk = 1'b0;
  logic        dec_valid, nomatch;
  logic [5:0]  outcome, synd;
  logic [11:0] off;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  ssr_access_router u_ssr_access_router (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(valid), .req_write_i(wr),
    .el_i(el), .op0_i(op0), .op1_i(op1), .crn_i(crn), .crm_i(crm), .op2_i(op2),
    .nv_i(nv), .host_mode_i(host), .lock_feat_i(feat), .lock_en_i(en),
    .halted_i(hlt), .lock_bit_i(lk), .dec_valid_o(dec_valid), .nomatch_o(nomatch),
    .outcome_o(outcome), .syndrome_o(synd), .mem_offset_o(off)
  );

  // packed expectation: {valid, nomatch, outcome[5:0], synd[5:0], off[11:0]}
  function automatic logic [25:0] model(output string tag);
    int   al;
    int   k;
    logic lock;
    logic [5:0] oh;
    al = 0;
    if (op0 == 2'b11 && crn == 4'b0100 && crm == 4'b0000 && op2 == 3'b000) begin
      if (op1 == 3'b000) al = 1;
      else if (op1 == 3'b101) al = 2;
      else if (op1 == 3'b100) al = 3;
    end
    if (al == 0) begin tag = "R1"; return {1'b0, 1'b1, 24'd0}; end
    lock = wr && (el == 2'd1 || el == 2'd2) && feat && en && !hlt && lk &&
           !(al == 1 && el == 2'd1 && nv[1:0] == 2'b11);
    if (el == 2'd0) begin k = 4; tag = "R2"; end
    else if (lock) begin k = 5; tag = "R7"; end
    else begin
      tag = (!wr && feat && en && !hlt && lk) ? "R8" : "R7";
      case (al)
        1: begin
          if (tag != "R8") tag = (el == 2'd1) ? "R3" : "R4";
          if (el == 2'd1) k = (nv == 3'b011) ? 3 : (nv == 3'b111) ? 2 : 0;
          else if (el == 2'd2) k = host ? 1 : 0;
          else k = 0;
        end
        2: begin
          if (tag != "R8") tag = "R5";
          if (el == 2'd1) k = (nv == 3'b101) ? 2 : nv[0] ? 3 : 4;
          else k = host ? 0 : 4;
        end
        default: begin
          if (tag != "R8") tag = "R6";
          if (el == 2'd1) k = (nv[2] && nv[0]) ? 0 : nv[0] ? 3 : 4;
          else k = 1;
        end
      endcase
    end
    oh = 6'd1 << k;
    return {1'b1, 1'b0, oh, (k == 3) ? 6'h18 : 6'h00, (k == 2) ? 12'h160 : 12'h000};
  endfunction

  task automatic compare(input logic [25:0] exp, input string tag);
    logic [25:0] act;
    act = {dec_valid, nomatch, outcome, synd, off};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h (el=%0d wr=%0b op1=%b nv=%b)",
               tag, act, exp, el, wr, op1, nv);
    end
  endtask

  // drive at a falling edge, check at the next falling edge
  task automatic issue();
    logic [25:0] exp;
    string tag;
    valid = 1'b1;
    exp = model(tag);
    @(negedge clk);
    compare(exp, tag);
    valid = 1'b0;
  endtask

  task automatic set_enc(input logic [2:0] o1);
    op0 = 2'b11; op1 = o1; crn = 4'b0100; crm = 4'b0000; op2 = 3'b000;
  endtask

  task automatic set_lock(input bit on);
    feat = on; en = on; hlt = 1'b0; lk = on;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    compare(26'd0, "R10");  // in reset
    rst_n = 1'b1;
    @(negedge clk);
    compare(26'd0, "R10");  // after release

    // R3: own alias at level 1, all patterns, read, lock off
    set_lock(0); wr = 1'b0; el = 2'd1; set_enc(3'b000);
    for (int p = 0; p < 8; p++) begin nv = 3'(p); issue(); end
    // R4
    for (int e = 2; e < 4; e++) begin
      for (int h = 0; h < 2; h++) begin el = 2'(e); host = h[0]; issue(); end
    end
    // R5, R6
    for (int a = 0; a < 2; a++) begin
      set_enc(a == 0 ? 3'b101 : 3'b100);
      for (int e = 1; e < 4; e++) begin
        for (int p = 0; p < 8; p++) begin
          for (int h = 0; h < 2; h++) begin
            el = 2'(e); nv = 3'(p); host = h[0]; issue();
          end
        end
      end
    end
    // R2: level 0 on all aliases, both directions
    el = 2'd0; set_lock(1);
    for (int a = 0; a < 3; a++) begin
      set_enc(a == 0 ? 3'b000 : a == 1 ? 3'b101 : 3'b100);
      for (int w = 0; w < 2; w++) begin wr = w[0]; issue(); end
    end
    // R7 exclusion sweep and R8 reads under full lock conditions
    for (int a = 0; a < 3; a++) begin
      set_enc(a == 0 ? 3'b000 : a == 1 ? 3'b101 : 3'b100);
      for (int e = 1; e < 4; e++) begin
        for (int p = 0; p < 8; p++) begin
          for (int w = 0; w < 2; w++) begin
            el = 2'(e); nv = 3'(p); wr = w[0]; issue();
          end
        end
      end
    end
    // R7: each single lock condition withheld
    el = 2'd2; wr = 1'b1; set_enc(3'b100);
    set_lock(1); feat = 1'b0; issue();
    set_lock(1); en = 1'b0; issue();
    set_lock(1); hlt = 1'b1; issue();
    set_lock(1); lk = 1'b0; issue();
    // R1: near-miss encodings
    set_lock(0); el = 2'd1;
    set_enc(3'b001); issue();
    set_enc(3'b000); op0 = 2'b10; issue();
    set_enc(3'b000); crn = 4'b0101; issue();
    set_enc(3'b000); crm = 4'b0001; issue();
    set_enc(3'b000); op2 = 3'b001; issue();
    // R9: idle cycle after a request
    @(negedge clk);
    compare(26'd0, "R9");

    // constrained random
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = $urandom % 8;
      case (r)
        0, 1: set_enc(3'b000);
        2, 3: set_enc(3'b101);
        4, 5: set_enc(3'b100);
        6: set_enc(3'($urandom));
        default: begin
          op0 = 2'($urandom); op1 = 3'($urandom); crn = 4'($urandom);
          crm = 4'($urandom); op2 = 3'($urandom);
        end
      endcase
      el = 2'($urandom); wr = 1'($urandom); nv = 3'($urandom); host = 1'($urandom);
      feat = ($urandom % 4) != 0; en = ($urandom % 4) != 0;
      hlt = ($urandom % 4) == 0; lk = ($urandom % 4) != 0;
      if ($urandom % 3 == 0) begin
        issue();
      end else begin
        @(negedge clk);
        compare(26'd0, "R9");
      end
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule